// File: doc/BRIEF.md
# Serial Converter Frame Output Interface

This block is the digital serial front of a 10-bit converter that hands its results to a DSP serial port. The host pulls chip select low, sends a frame-sync pulse, and supplies a serial clock. The block then sends one 16-bit word per frame: six zero padding bits followed by the result, most significant bit first. After the word it releases the data line and enters auto power-down until the next frame-sync rising edge. A 10-bit parallel input stands in for the analog result.

Every pin is treated as a synchronous input to a faster system clock `clk`, and edges of chip select, frame sync and serial clock are found by comparing each pin with its registered copy. Any output change therefore appears one `clk` edge after the pin edge that causes it. The tri-state data pin is modelled as a data bit `doData` plus an output enable `doOe`, where high impedance means `doOe` is 0. The pad-side buffer combines the two.

Whether the interface runs in DSP mode is decided once, when chip select falls. Only DSP-mode framing is implemented. In the other mode the line is never driven.

Top module: `sadc_frame_if`

## Requirements
- R1: When csN falls, the level of fs is latched as the mode: fs low selects DSP mode and fs high selects microcontroller mode. In microcontroller mode, fs rising edges start no frame, doOe stays 0 and powerDown stays 1.
- R2: While csN is high, doOe is 0 one clk edge later and powerDown is 1. A frame in progress is abandoned.
- R3: In DSP mode with no frame in progress, an fs rising edge starts a frame. On the next clk edge doOe becomes 1, doData is 0 and powerDown becomes 0.
- R4: The frame word is {6'b000000, result[9:0]}. On the k-th counted sclk rising edge (k = 1..16), doData takes word bit 16-k. Edges 1 to 6 therefore send zeros, and edges 7 to 16 send result[9] down to result[0].
- R5: sampleIn is captured on the 6th counted sclk rising edge, which closes the sampling window. Later changes of sampleIn do not alter the bits of that frame.
- R6: On the 17th counted sclk rising edge the line is released: doOe becomes 0 and doData is 0.
- R7: On the 17th counted sclk falling edge powerDown becomes 1 and the frame ends. powerDown stays 0 during the frame.
- R8: An fs rising edge during a frame is ignored, and the word continues unchanged. protoErr is high for exactly one clk cycle in response.
- R9: While rstN is low (synchronous, active low), doOe is 0, doData is 0, powerDown is 1 and protoErr is 0. The edge counters are cleared, so the next frame starts from edge 1.
- R10: sclk edges are counted only once fs has gone low in the frame. Edges that occur while the frame-sync pulse is still high do not advance the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| fs | input | 1 | Frame sync from the host |
| sclk | input | 1 | Serial clock from the host |
| sampleIn | input | 10 | Parallel conversion result to be sent |
| doData | output | 1 | Serial data bit |
| doOe | output | 1 | Serial data drive enable; 0 means high impedance |
| powerDown | output | 1 | Auto power-down status |
| protoErr | output | 1 | One-cycle pulse on a frame sync edge received mid-frame |

## Verification
Some rules hold on every cycle, and the bound checker tests them continuously:
- chip select high releases the line;
- a released line carries a zero;
- the line is never driven while powered down;
- each frame start drives a zero with power-down cleared;
- the error flag never lasts two cycles.

Other properties can only be shown by the bench's scenarios, because they depend on counted edge positions across a whole frame:
- the bit order and the exact edge on which each bit appears;
- the capture point of the sample;
- ignoring edges while frame sync is high;
- the 17th-edge release and power-down;
- the mode decision on the chip-select edge.

The bench sweeps every 10-bit result value and varies the frame scenario from one value to the next.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  // Strobes issued by the control to the datapath, one clk cycle wide.
  typedef struct packed {
    logic start;    // frame begins: drive the line, first bit zero
    logic pad;      // send a padding zero
    logic capture;  // latch the parallel result
    logic shift;    // send next result bit
    logic release_; // let the line float
  } dpStrobe_t;
endpackage

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int PAD_BITS = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      fs,
  input  logic      sclk,
  output dpStrobe_t strobe,
  output logic      powerDown,
  output logic      protoErr
);
  localparam int WORD_BITS = PAD_BITS + RES_BITS;
  localparam int CNT_W = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_BITS);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(WORD_BITS + 1);

  logic csPrev, fsPrev, sclkPrev;
  logic dspMode, active, armed;
  logic [CNT_W-1:0] riseCnt, fallCnt;

  logic csFall, fsRise, sRise, sFall, enabled, counting;
  logic frameReq, startOk, countRise, countFall;
  logic [CNT_W-1:0] riseNext, fallNext;

  assign csFall    = csPrev & ~csN;
  assign fsRise    = ~fsPrev & fs;
  assign sRise     = ~sclkPrev & sclk;
  assign sFall     = sclkPrev & ~sclk;
  assign enabled   = ~csN;
  assign counting  = active & (armed | ~fs);
  assign frameReq  = enabled & dspMode & fsRise;
  assign startOk   = frameReq & ~active;
  assign riseNext  = riseCnt + CNT_W'(1);
  assign fallNext  = fallCnt + CNT_W'(1);
  assign countRise = counting & sRise & (riseCnt < LAST_EDGE);
  assign countFall = counting & sFall;

  always_comb begin
    strobe          = '0;
    strobe.start    = startOk;
    strobe.pad      = countRise && (riseNext <= PAD_LAST);
    strobe.capture  = countRise && (riseNext == PAD_LAST);
    strobe.shift    = countRise && (riseNext > PAD_LAST) && (riseNext < LAST_EDGE);
    strobe.release_ = ~enabled | (countRise && (riseNext == LAST_EDGE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev    <= 1'b1;
      fsPrev    <= 1'b0;
      sclkPrev  <= 1'b0;
      dspMode   <= 1'b0;
      active    <= 1'b0;
      armed     <= 1'b0;
      riseCnt   <= '0;
      fallCnt   <= '0;
      powerDown <= 1'b1;
      protoErr  <= 1'b0;
    end else begin
      csPrev   <= csN;
      fsPrev   <= fs;
      sclkPrev <= sclk;
      protoErr <= frameReq & active;
      if (csFall) dspMode <= ~fs;
      if (!enabled) begin
        active    <= 1'b0;
        armed     <= 1'b0;
        riseCnt   <= '0;
        fallCnt   <= '0;
        powerDown <= 1'b1;
      end else if (startOk) begin
        active    <= 1'b1;
        armed     <= 1'b0;
        riseCnt   <= '0;
        fallCnt   <= '0;
        powerDown <= 1'b0;
      end else if (active) begin
        if (!fs) armed <= 1'b1;
        if (countRise) riseCnt <= riseNext;
        if (countFall) begin
          if (fallNext == LAST_EDGE) begin
            active    <= 1'b0;
            armed     <= 1'b0;
            riseCnt   <= '0;
            fallCnt   <= '0;
            powerDown <= 1'b1;
          end else begin
            fallCnt <= fallNext;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [RES_BITS-1:0] sampleIn,
  output logic                doData,
  output logic                doOe
);
  logic [RES_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      doData   <= 1'b0;
      doOe     <= 1'b0;
    end else if (strobe.release_) begin
      doData <= 1'b0;
      doOe   <= 1'b0;
    end else begin
      if (strobe.start) begin
        doOe   <= 1'b1;
        doData <= 1'b0;
      end
      if (strobe.pad) doData <= 1'b0;
      if (strobe.capture) shiftReg <= sampleIn;
      if (strobe.shift) begin
        doData   <= shiftReg[RES_BITS-1];
        shiftReg <= {shiftReg[RES_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sadc_frame_if.sv
module sadc_frame_if
  import sadc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int PAD_BITS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                fs,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sampleIn,
  output logic                doData,
  output logic                doOe,
  output logic                powerDown,
  output logic                protoErr
);
  dpStrobe_t strobe;

  sadc_ctrl #(.RES_BITS(RES_BITS), .PAD_BITS(PAD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .fs(fs), .sclk(sclk),
    .strobe(strobe), .powerDown(powerDown), .protoErr(protoErr)
  );

  sadc_datapath #(.RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .doData(doData), .doOe(doOe)
  );
endmodule

// File: rtl/sadc_frame_checker.sv
module sadc_frame_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic doData,
  input logic doOe,
  input logic powerDown,
  input logic protoErr
);
  // R2
  a_r2_cs_high_releases: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !doOe);
  // R3
  a_r3_start_zero_awake: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doOe) |-> (!doData && !powerDown));
  // R7
  a_r7_asleep_not_driving: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> !doOe);
  // R6
  a_r6_released_line_zero: assert property (@(posedge clk) disable iff (!rstN)
    !doOe |-> !doData);
  // R8
  a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> !protoErr);
endmodule

bind sadc_frame_if sadc_frame_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .doData(doData), .doOe(doOe),
  .powerDown(powerDown), .protoErr(protoErr)
);

// File: tb/tb_sadc_frame_if.sv
`timescale 1ns/1ps
module tb_sadc_frame_if;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic fs = 1'b0;
  logic sclk = 1'b0;
  logic [9:0] sampleIn = '0;
  logic doData, doOe, powerDown, protoErr;
  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sadc_frame_if dut (
    .clk(clk), .rstN(rstN), .csN(csN), .fs(fs), .sclk(sclk),
    .sampleIn(sampleIn), .doData(doData), .doOe(doOe),
    .powerDown(powerDown), .protoErr(protoErr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic enterDsp();
    csN = 1'b1; tick(2);
    fs = 1'b0; sclk = 1'b0; tick(1);
    csN = 1'b0; tick(2);
  endtask

  // opt: 0 plain, 1 sample changes after capture (R5),
  //      2 sclk edges while fs still high (R10), 3 mid-frame fs edge (R8)
  task automatic runFrame(input logic [9:0] val, input int opt);
    int expBit;
    sampleIn = val;
    fs = 1'b1; tick(2);
    check("R3 oe at start", doOe, 1);
    check("R3 data at start", doData, 0);
    check("R3 powerDown at start", powerDown, 0);
    if (opt == 2) begin
      for (int p = 0; p < 3; p++) begin
        sclk = 1'b1; tick(2);
        sclk = 1'b0; tick(2);
      end
      check("R10 still driving zero", doOe * 2 + doData, 2);
    end
    fs = 1'b0; tick(2);
    for (int k = 1; k <= 17; k++) begin
      sclk = 1'b1; tick(2);
      if (k <= 16) begin
        expBit = (k <= 6) ? 0 : int'(val[16-k]);
        check((k <= 6) ? "R4 pad bit" : (opt == 2 ? "R10 result bit" : "R4 result bit"),
              doData, expBit);
        check("R4 oe in frame", doOe, 1);
      end else begin
        check("R6 oe after 17th rise", doOe, 0);
        check("R6 data after 17th rise", doData, 0);
        check("R7 awake before 17th fall", powerDown, 0);
      end
      if (k == 6 && opt == 1) sampleIn = ~val; // R5: too late to matter
      if (k == 8 && opt == 3) begin
        fs = 1'b1; tick(1);
        check("R8 err pulse", protoErr, 1);
        tick(1);
        check("R8 err one cycle", protoErr, 0);
        fs = 1'b0; tick(2);
      end
      sclk = 1'b0; tick(2);
      if (k == 17) check("R7 powerDown after 17th fall", powerDown, 1);
    end
  endtask

  initial begin
    // R9: reset state
    tick(3);
    check("R9 oe in reset", doOe, 0);
    check("R9 data in reset", doData, 0);
    check("R9 powerDown in reset", powerDown, 1);
    check("R9 err in reset", protoErr, 0);
    rstN = 1'b1; tick(2);

    // R1: fs high at chip-select fall selects the other mode; no frame
    fs = 1'b1; tick(2);
    csN = 1'b0; tick(2);
    fs = 1'b0; tick(2);
    fs = 1'b1; tick(2);
    check("R1 no drive in other mode", doOe, 0);
    check("R1 asleep in other mode", powerDown, 1);
    fs = 1'b0; tick(1);
    for (int k = 0; k < 17; k++) begin
      sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    end
    check("R1 still released", doOe, 0);

    // R1: fs low at chip-select fall selects DSP mode
    enterDsp();
    runFrame(10'h2A5, 0);

    // Exhaustive sweep of result values with rotating scenarios
    for (int v = 0; v < 1024; v++) runFrame(10'(v), v % 4);

    // R2: chip select high mid-frame
    sampleIn = 10'h3FF;
    fs = 1'b1; tick(2); fs = 1'b0; tick(2);
    for (int k = 0; k < 9; k++) begin
      sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    end
    csN = 1'b1; tick(2);
    check("R2 released on cs high", doOe, 0);
    check("R2 asleep on cs high", powerDown, 1);
    fs = 1'b1; tick(2);
    check("R2 fs ignored while disabled", doOe, 0);
    fs = 1'b0;
    enterDsp();
    runFrame(10'h155, 0);

    // R9: reset mid-frame, then a full frame from edge 1
    fs = 1'b1; tick(2); fs = 1'b0; tick(2);
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    end
    rstN = 1'b0; tick(2);
    check("R9 oe after mid-frame reset", doOe, 0);
    check("R9 powerDown after mid-frame reset", powerDown, 1);
    csN = 1'b1; rstN = 1'b1; tick(2);
    enterDsp();
    runFrame(10'h301, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule